// File: doc/BRIEF.md
# Gathering Descriptor Ring Copy Engine

This block is a single-channel copy engine. Descriptors live in a small on-chip descriptor memory and are organised as two rings. The producer fills the source ring with descriptors naming payload buffers. The consumer stocks the destination ring with descriptors naming empty receive buffers. A register port programs each ring's base entry, entry count and producer write index, and sets a per-descriptor length cap. The engine walks the source ring and copies payload words through a word-wide memory port into the buffer named by the oldest open destination descriptor. When the buffer completes, the engine writes the received byte count into that destination descriptor, advances the destination read index and pulses a completion event.

Source descriptors flagged as gather are chained into one destination buffer, so a scattered message costs one destination descriptor and one completion. The consumer treats a zero byte count in a destination descriptor as "not yet filled". Host software polls the hardware read indices and the free-entry counts through the register port.

Top module: `ring_copy_engine`

## Requirements
- R1: A descriptor is 64 bits: buffer byte address in [31:0], byte count in [47:32], flags in [63:48]. Flag bit 0 is gather, flag bit 1 is byte swap, and flag bits [15:4] carry a transfer id that the engine does not interpret. On completion the engine rewrites the destination descriptor with its original address and flags and the new byte count.
- R2: Register 1 (source) and register 5 (destination) hold the ring's entry count, which is a power of two. Register 0 and register 4 hold the base entry. Ring index n maps to descriptor entry base+n. Every read index advance wraps modulo the entry count.
- R3: Register 3 reads the source free-entry count, (read_index - 1 - write_index) masked by count-1. Register 7 bits [15:8] read the same value for the destination ring, so one slot always stays unused.
- R4: The engine processes source descriptors from its read index up to, but not including, the write index in register 2. The source read index (register 2 on read) advances once per completed descriptor.
- R5: A descriptor of L bytes copies ceil(L/4) whole 32-bit words. The words are read from consecutive word addresses starting at the source address and written to consecutive word addresses at the destination, with a read latency of one cycle.
- R6: A run of gather-flagged source descriptors, ended by one without the flag, fills one destination buffer contiguously. The run produces a single completion, and its byte count is the sum of the run.
- R7: Until its buffer completes, a destination descriptor's byte count stays zero. The count is written first, and the destination read index (register 6 on read) advances afterwards. done_o pulses for one cycle in the first cycle the new index is visible.
- R8: With the byte-swap flag set, every copied word has its four bytes reversed.
- R9: Register 3 on write sets the length cap. A longer source count is truncated to the cap and sets sticky err_o, which is also readable at register 7 bit 0. Writing 1 to register 7 bit 0 clears it.
- R10: While no destination buffer is open and the destination ring is empty (read index equals write index), the engine stalls without memory traffic and keeps the source data pending.
- R11: A ring whose entry count register is zero is disabled. The engine moves neither its indices nor any data.
- R12: After reset all indices, the sticky error, done_o and mem_req_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| desc_we_i | input | 1 | Host descriptor write strobe |
| desc_waddr_i | input | IW | Host descriptor write entry |
| desc_wdata_i | input | 64 | Host descriptor write data |
| desc_raddr_i | input | IW | Host descriptor read entry |
| desc_rdata_o | output | 64 | Host descriptor read data (combinational) |
| mem_req_o | output | 1 | Payload memory access request |
| mem_we_o | output | 1 | Payload memory write (else read) |
| mem_addr_o | output | 32 | Payload byte address, word aligned |
| mem_wdata_o | output | 32 | Payload write data |
| mem_rdata_i | input | 32 | Payload read data, one cycle after a read |
| done_o | output | 1 | Copy-complete pulse |
| err_o | output | 1 | Sticky truncation error |

## Verification
The main copy path is exercised with four input shapes. A plain two-word descriptor checks address stepping and that the transfer id is ignored. A byte-swapped word separates swapped data from straight data. A three-descriptor gather run separates one merged completion from per-descriptor completions. An over-long descriptor separates truncation from a full copy, using a sentinel word past the cap. The remaining patterns toggle the conditions around the copy. An empty destination ring must hold the source pending. A disabled source ring must freeze its index. Stopping a gather run midway must leave the destination count at zero. These patterns also drive both rings through an index wrap.

// File: rtl/cpe_pkg.sv
package cpe_pkg;
  localparam int FLAG_GATHER = 0;
  localparam int FLAG_SWAP   = 1;

  typedef struct packed {
    logic [15:0] flags;
    logic [15:0] nbytes;
    logic [31:0] addr;
  } desc_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_WR, S_SRC_DONE, S_DST_WB, S_DST_ADV
  } eng_state_e;

  function automatic logic [31:0] bswap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/cpe_desc_mem.sv
module cpe_desc_mem #(
  parameter int DEPTH = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_we_i,
  input  logic [IW-1:0] host_waddr_i,
  input  logic [63:0]   host_wdata_i,
  input  logic [IW-1:0] host_raddr_i,
  output logic [63:0]   host_rdata_o,
  input  logic          eng_we_i,
  input  logic [IW-1:0] eng_waddr_i,
  input  logic [63:0]   eng_wdata_i,
  input  logic [IW-1:0] src_raddr_i,
  output logic [63:0]   src_rdata_o,
  input  logic [IW-1:0] dst_raddr_i,
  output logic [63:0]   dst_rdata_o
);
  logic [63:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (host_we_i) mem_q[host_waddr_i] <= host_wdata_i;
      // engine write-back wins a same-entry collision
      if (eng_we_i)  mem_q[eng_waddr_i]  <= eng_wdata_i;
    end
  end

  assign host_rdata_o = mem_q[host_raddr_i];
  assign src_rdata_o  = mem_q[src_raddr_i];
  assign dst_rdata_o  = mem_q[dst_raddr_i];
endmodule

// File: rtl/cpe_regs.sv
module cpe_regs #(
  parameter int IW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic [IW-1:0] src_rd_i,
  input  logic [IW-1:0] dst_rd_i,
  input  logic          err_set_i,
  output logic [IW-1:0] src_base_o,
  output logic [IW:0]   src_size_o,
  output logic [IW-1:0] src_wr_o,
  output logic [IW-1:0] dst_base_o,
  output logic [IW:0]   dst_size_o,
  output logic [IW-1:0] dst_wr_o,
  output logic [15:0]   max_len_o,
  output logic          err_o
);
  logic [IW-1:0] src_base_q, src_wr_q, dst_base_q, dst_wr_q;
  logic [IW:0]   src_size_q, dst_size_q;
  logic [15:0]   max_len_q;
  logic          err_q;
  logic          err_clr;
  logic [IW:0]   src_m1, dst_m1;
  logic [IW-1:0] src_free, dst_free;

  assign err_clr = we_i && (addr_i == 3'd7) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_base_q <= '0; src_size_q <= '0; src_wr_q <= '0;
      dst_base_q <= '0; dst_size_q <= '0; dst_wr_q <= '0;
      max_len_q  <= '0; err_q      <= 1'b0;
    end else begin
      if (we_i) begin
        unique case (addr_i)
          3'd0: src_base_q <= wdata_i[IW-1:0];
          3'd1: src_size_q <= wdata_i[IW:0];
          3'd2: src_wr_q   <= wdata_i[IW-1:0];
          3'd3: max_len_q  <= wdata_i[15:0];
          3'd4: dst_base_q <= wdata_i[IW-1:0];
          3'd5: dst_size_q <= wdata_i[IW:0];
          3'd6: dst_wr_q   <= wdata_i[IW-1:0];
          default: ;
        endcase
      end
      if (err_set_i)    err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  assign src_m1   = src_size_q - (IW+1)'(1);
  assign dst_m1   = dst_size_q - (IW+1)'(1);
  assign src_free = (src_rd_i - IW'(1) - src_wr_q) & src_m1[IW-1:0];
  assign dst_free = (dst_rd_i - IW'(1) - dst_wr_q) & dst_m1[IW-1:0];

  always_comb begin
    unique case (addr_i)
      3'd0: rdata_o = 32'(src_base_q);
      3'd1: rdata_o = 32'(src_size_q);
      3'd2: rdata_o = 32'(src_rd_i);
      3'd3: rdata_o = 32'(src_free);
      3'd4: rdata_o = 32'(dst_base_q);
      3'd5: rdata_o = 32'(dst_size_q);
      3'd6: rdata_o = 32'(dst_rd_i);
      default: rdata_o = {16'h0, 8'(dst_free), 7'h0, err_q};
    endcase
  end

  assign src_base_o = src_base_q;
  assign src_size_o = src_size_q;
  assign src_wr_o   = src_wr_q;
  assign dst_base_o = dst_base_q;
  assign dst_size_o = dst_size_q;
  assign dst_wr_o   = dst_wr_q;
  assign max_len_o  = max_len_q;
  assign err_o      = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(err_set_i || (err_q && !err_clr)) |-> err_q); // R9
endmodule

// File: rtl/cpe_engine.sv
module cpe_engine
  import cpe_pkg::*;
#(
  parameter int IW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] src_base_i,
  input  logic [IW:0]   src_size_i,
  input  logic [IW-1:0] src_wr_i,
  input  logic [IW-1:0] dst_base_i,
  input  logic [IW:0]   dst_size_i,
  input  logic [IW-1:0] dst_wr_i,
  input  logic [15:0]   max_len_i,
  output logic [IW-1:0] src_rd_o,
  output logic [IW-1:0] dst_rd_o,
  output logic          err_set_o,
  output logic [IW-1:0] src_raddr_o,
  input  logic [63:0]   src_rdata_i,
  output logic [IW-1:0] dst_raddr_o,
  input  logic [63:0]   dst_rdata_i,
  output logic          desc_we_o,
  output logic [IW-1:0] desc_waddr_o,
  output logic [63:0]   desc_wdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [31:0]   mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          done_o
);
  eng_state_e    state_q;
  logic [IW-1:0] src_rd_q, dst_rd_q;
  logic [31:0]   s_ptr_q, d_ptr_q;
  logic [14:0]   words_q;
  logic [15:0]   cur_len_q, acc_q;
  logic          swap_q, gather_q, open_q, done_q;
  desc_t         d_desc_q;

  desc_t         src_d, dst_d;
  logic [IW:0]   s_m1, d_m1;
  logic [IW-1:0] mask_s, mask_d;
  logic          src_pend, dst_avail, go, over;
  logic [15:0]   take_len;
  logic [16:0]   take_words;

  assign src_d = desc_t'(src_rdata_i);
  assign dst_d = desc_t'(dst_rdata_i);

  assign s_m1   = src_size_i - (IW+1)'(1);
  assign d_m1   = dst_size_i - (IW+1)'(1);
  assign mask_s = s_m1[IW-1:0];
  assign mask_d = d_m1[IW-1:0];

  assign src_pend  = (src_size_i != '0) && (((src_wr_i ^ src_rd_q) & mask_s) != '0);
  assign dst_avail = (dst_size_i != '0) && (((dst_wr_i ^ dst_rd_q) & mask_d) != '0);
  assign go        = (state_q == S_IDLE) && src_pend && (open_q || dst_avail);

  assign over       = src_d.nbytes > max_len_i;
  assign take_len   = over ? max_len_i : src_d.nbytes;
  assign take_words = ({1'b0, take_len} + 17'd3) >> 2;
  assign err_set_o  = go && over;

  assign src_raddr_o = src_base_i + src_rd_q;
  assign dst_raddr_o = dst_base_i + dst_rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      src_rd_q  <= '0;
      dst_rd_q  <= '0;
      s_ptr_q   <= '0;
      d_ptr_q   <= '0;
      words_q   <= '0;
      cur_len_q <= '0;
      acc_q     <= '0;
      swap_q    <= 1'b0;
      gather_q  <= 1'b0;
      open_q    <= 1'b0;
      done_q    <= 1'b0;
      d_desc_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (go) begin
          s_ptr_q   <= src_d.addr;
          cur_len_q <= take_len;
          words_q   <= take_words[14:0];
          swap_q    <= src_d.flags[FLAG_SWAP];
          gather_q  <= src_d.flags[FLAG_GATHER];
          if (!open_q) begin
            d_ptr_q  <= dst_d.addr;
            d_desc_q <= dst_d;
            acc_q    <= '0;
            open_q   <= 1'b1;
          end
          state_q <= (take_words == '0) ? S_SRC_DONE : S_RD;
        end
        S_RD: state_q <= S_WR;
        S_WR: begin
          s_ptr_q <= s_ptr_q + 32'd4;
          d_ptr_q <= d_ptr_q + 32'd4;
          words_q <= words_q - 15'd1;
          state_q <= (words_q == 15'd1) ? S_SRC_DONE : S_RD;
        end
        S_SRC_DONE: begin
          src_rd_q <= (src_rd_q + IW'(1)) & mask_s;
          acc_q    <= acc_q + cur_len_q;
          state_q  <= gather_q ? S_IDLE : S_DST_WB;
        end
        S_DST_WB: state_q <= S_DST_ADV;
        S_DST_ADV: begin
          dst_rd_q <= (dst_rd_q + IW'(1)) & mask_d;
          done_q   <= 1'b1;
          open_q   <= 1'b0;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (state_q == S_RD) || (state_q == S_WR);
  assign mem_we_o    = (state_q == S_WR);
  assign mem_addr_o  = (state_q == S_WR) ? d_ptr_q : s_ptr_q;
  assign mem_wdata_o = swap_q ? bswap32(mem_rdata_i) : mem_rdata_i;

  assign desc_we_o    = (state_q == S_DST_WB);
  assign desc_waddr_o = dst_raddr_o;
  assign desc_wdata_o = {d_desc_q.flags, acc_q, d_desc_q.addr};

  assign src_rd_o = src_rd_q;
  assign dst_rd_o = dst_rd_q;
  assign done_o   = done_q;

  AST_SRC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_rd_q != $past(src_rd_q)) |-> (src_rd_q == (($past(src_rd_q) + IW'(1)) & $past(mask_s)))); // R2
  AST_DISABLED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(src_size_i) == '0) |-> $stable(src_rd_q)); // R11
  AST_WB_BEFORE_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_rd_q != $past(dst_rd_q)) |-> $past(desc_we_o, 2)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R7
  AST_DRY_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && !open_q && !dst_avail) |=> !mem_req_o); // R10
endmodule

// File: rtl/ring_copy_engine.sv
module ring_copy_engine #(
  parameter int DESC_DEPTH = 32,
  localparam int IW = $clog2(DESC_DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          desc_we_i,
  input  logic [IW-1:0] desc_waddr_i,
  input  logic [63:0]   desc_wdata_i,
  input  logic [IW-1:0] desc_raddr_i,
  output logic [63:0]   desc_rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [31:0]   mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          done_o,
  output logic          err_o
);
  logic [IW-1:0] src_base, src_wr, dst_base, dst_wr, src_rd, dst_rd;
  logic [IW:0]   src_size, dst_size;
  logic [15:0]   max_len;
  logic          err_set;
  logic [IW-1:0] src_raddr, dst_raddr, eng_waddr;
  logic [63:0]   src_rdata, dst_rdata, eng_wdata;
  logic          eng_we;

  cpe_regs #(.IW(IW)) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .src_rd_i(src_rd), .dst_rd_i(dst_rd), .err_set_i(err_set),
    .src_base_o(src_base), .src_size_o(src_size), .src_wr_o(src_wr),
    .dst_base_o(dst_base), .dst_size_o(dst_size), .dst_wr_o(dst_wr),
    .max_len_o(max_len), .err_o(err_o)
  );

  cpe_desc_mem #(.DEPTH(DESC_DEPTH)) i_desc_mem (
    .clk_i, .rst_ni,
    .host_we_i(desc_we_i), .host_waddr_i(desc_waddr_i), .host_wdata_i(desc_wdata_i),
    .host_raddr_i(desc_raddr_i), .host_rdata_o(desc_rdata_o),
    .eng_we_i(eng_we), .eng_waddr_i(eng_waddr), .eng_wdata_i(eng_wdata),
    .src_raddr_i(src_raddr), .src_rdata_o(src_rdata),
    .dst_raddr_i(dst_raddr), .dst_rdata_o(dst_rdata)
  );

  cpe_engine #(.IW(IW)) i_engine (
    .clk_i, .rst_ni,
    .src_base_i(src_base), .src_size_i(src_size), .src_wr_i(src_wr),
    .dst_base_i(dst_base), .dst_size_i(dst_size), .dst_wr_i(dst_wr),
    .max_len_i(max_len),
    .src_rd_o(src_rd), .dst_rd_o(dst_rd), .err_set_o(err_set),
    .src_raddr_o(src_raddr), .src_rdata_i(src_rdata),
    .dst_raddr_o(dst_raddr), .dst_rdata_i(dst_rdata),
    .desc_we_o(eng_we), .desc_waddr_o(eng_waddr), .desc_wdata_o(eng_wdata),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i,
    .done_o
  );
endmodule

// File: tb/test_ring_copy_engine.sv
module test_ring_copy_engine;
  localparam int DEPTH = 32;
  localparam int IW = $clog2(DEPTH);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [2:0]    reg_addr_i = '0;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic          desc_we_i = 1'b0;
  logic [IW-1:0] desc_waddr_i = '0;
  logic [63:0]   desc_wdata_i = '0;
  logic [IW-1:0] desc_raddr_i = '0;
  logic [63:0]   desc_rdata_o;
  logic          mem_req_o, mem_we_o;
  logic [31:0]   mem_addr_o, mem_wdata_o;
  logic [31:0]   mem_rdata_i = '0;
  logic          done_o, err_o;

  always #5 clk_i = ~clk_i;

  ring_copy_engine #(.DESC_DEPTH(DEPTH)) i_ring_copy_engine (.*);

  logic [31:0] mem [256];
  always @(posedge clk_i) begin
    if (mem_req_o && mem_we_o)  mem[mem_addr_o[9:2]] <= mem_wdata_o;
    if (mem_req_o && !mem_we_o) mem_rdata_i <= mem[mem_addr_o[9:2]];
  end

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int req_cnt = 0;
  logic [63:0] exp_q [$];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every completion pops one expected destination descriptor
  always @(negedge clk_i) begin
    if (rst_ni && mem_req_o) req_cnt++;
    if (rst_ni && done_o) begin
      done_cnt++;
      if (exp_q.size() == 0) check(1'b0, "R6 unexpected completion", 64'(done_cnt), 64'(0));
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        check(desc_rdata_o == e, "R7 dst descriptor", desc_rdata_o, e);
      end
    end
  end

  task automatic expect_done(input logic [63:0] d);
    exp_q.push_back(d);
  endtask

  task automatic reg_wr(input int a, input int d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 3'(a); reg_wdata_i = 32'(d);
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input int a, output logic [31:0] v);
    @(negedge clk_i);
    reg_addr_i = 3'(a);
    #1 v = reg_rdata_o;
  endtask

  task automatic desc_wr(input int idx, input logic [63:0] v);
    @(negedge clk_i);
    desc_we_i = 1'b1; desc_waddr_i = IW'(idx); desc_wdata_i = v;
    @(negedge clk_i);
    desc_we_i = 1'b0;
  endtask

  task automatic wait_done(input int target);
    for (int i = 0; i < 2000 && done_cnt < target; i++) @(negedge clk_i);
    check(done_cnt >= target, "R4 completion arrives", 64'(done_cnt), 64'(target));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int dc, rc;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk_i);
    // R12 reset state
    check(done_o == 1'b0 && err_o == 1'b0 && mem_req_o == 1'b0, "R12 outputs quiet", 64'({done_o, err_o, mem_req_o}), 64'(0));
    rst_ni = 1'b1;
    reg_rd(2, v); check(v == 0, "R12 src read index", 64'(v), 64'(0));
    reg_rd(6, v); check(v == 0, "R12 dst read index", 64'(v), 64'(0));

    reg_wr(0, 0); reg_wr(1, 8); reg_wr(4, 16); reg_wr(5, 4); reg_wr(3, 64);
    reg_rd(3, v); check(v == 7, "R3 src free empty ring", 64'(v), 64'(7));

    // plain copy, transfer id ignored, dst flags kept
    mem[0] = 32'h11223344; mem[1] = 32'h55667788;
    desc_wr(16, {16'h00A0, 16'd0, 32'h200});
    desc_raddr_i = IW'(16);
    reg_wr(6, 1);
    reg_rd(7, v); check(v[15:8] == 2, "R3 dst free", 64'(v[15:8]), 64'(2));
    desc_wr(0, {16'h0050, 16'd8, 32'h000});
    expect_done({16'h00A0, 16'd8, 32'h200});
    reg_wr(2, 1);
    wait_done(1);
    check(mem[128] == 32'h11223344, "R5 word 0", 64'(mem[128]), 64'h11223344);
    check(mem[129] == 32'h55667788, "R5 word 1", 64'(mem[129]), 64'h55667788);
    reg_rd(2, v); check(v == 1, "R4 src index advanced", 64'(v), 64'(1));
    reg_rd(6, v); check(v == 1, "R7 dst index advanced", 64'(v), 64'(1));
    check(exp_q.size() == 0, "R1 descriptor layout", 64'(exp_q.size()), 64'(0));

    // byte swap
    mem[4] = 32'hA1B2C3D4;
    desc_wr(17, {16'h0, 16'd0, 32'h240});
    desc_raddr_i = IW'(17);
    reg_wr(6, 2);
    desc_wr(1, {16'h0002, 16'd4, 32'h010});
    expect_done({16'h0, 16'd4, 32'h240});
    reg_wr(2, 2);
    wait_done(2);
    check(mem[144] == 32'hD4C3B2A1, "R8 swapped word", 64'(mem[144]), 64'hD4C3B2A1);

    // gather run of three
    mem[8] = 32'hC0000001; mem[9] = 32'hC0000002; mem[12] = 32'hC0000003; mem[16] = 32'hC0000004;
    desc_wr(18, {16'h0, 16'd0, 32'h280});
    desc_raddr_i = IW'(18);
    reg_wr(6, 3);
    desc_wr(2, {16'h0001, 16'd8, 32'h020});
    desc_wr(3, {16'h0011, 16'd4, 32'h030});
    desc_wr(4, {16'h0000, 16'd4, 32'h040});
    reg_wr(2, 4);
    repeat (40) @(negedge clk_i);
    reg_rd(2, v); check(v == 4, "R6 gather partial src index", 64'(v), 64'(4));
    check(desc_rdata_o[47:32] == 16'd0, "R7 count zero before done", 64'(desc_rdata_o[47:32]), 64'(0));
    check(done_cnt == 2, "R6 no early completion", 64'(done_cnt), 64'(2));
    expect_done({16'h0, 16'd16, 32'h280});
    reg_wr(2, 5);
    wait_done(3);
    repeat (10) @(negedge clk_i);
    check(done_cnt == 3, "R6 single completion", 64'(done_cnt), 64'(3));
    check(mem[160] == 32'hC0000001 && mem[161] == 32'hC0000002, "R6 first part", 64'({mem[160], mem[161]}), {32'hC0000001, 32'hC0000002});
    check(mem[162] == 32'hC0000003 && mem[163] == 32'hC0000004, "R6 later parts", 64'({mem[162], mem[163]}), {32'hC0000003, 32'hC0000004});

    // stall on empty destination ring
    mem[20] = 32'h5A5A0005;
    desc_wr(5, {16'h0, 16'd4, 32'h050});
    dc = done_cnt; rc = req_cnt;
    reg_wr(2, 6);
    repeat (30) @(negedge clk_i);
    reg_rd(2, v); check(v == 5, "R10 src held pending", 64'(v), 64'(5));
    check(req_cnt == rc, "R10 no memory traffic", 64'(req_cnt), 64'(rc));
    check(done_cnt == dc, "R10 no completion", 64'(done_cnt), 64'(dc));
    reg_rd(3, v); check(v == 6, "R3 src free one pending", 64'(v), 64'(6));
    desc_wr(19, {16'h0, 16'd0, 32'h2C0});
    desc_raddr_i = IW'(19);
    expect_done({16'h0, 16'd4, 32'h2C0});
    reg_wr(6, 0);
    wait_done(4);
    check(mem[176] == 32'h5A5A0005, "R10 data delivered after stall", 64'(mem[176]), 64'h5A5A0005);
    reg_rd(6, v); check(v == 0, "R2 dst index wraps", 64'(v), 64'(0));

    // truncation to cap
    reg_wr(3, 4);
    mem[24] = 32'h0000AAAA; mem[25] = 32'h0000BBBB; mem[193] = 32'hDEADBEEF;
    desc_wr(16, {16'h0, 16'd0, 32'h300});
    desc_raddr_i = IW'(16);
    reg_wr(6, 1);
    desc_wr(6, {16'h0, 16'd12, 32'h060});
    expect_done({16'h0, 16'd4, 32'h300});
    reg_wr(2, 7);
    wait_done(5);
    check(mem[192] == 32'h0000AAAA, "R9 first word copied", 64'(mem[192]), 64'h0000AAAA);
    check(mem[193] == 32'hDEADBEEF, "R9 beyond cap untouched", 64'(mem[193]), 64'hDEADBEEF);
    check(err_o == 1'b1, "R9 sticky error set", 64'(err_o), 64'(1));
    reg_rd(7, v); check(v[0] == 1'b1, "R9 error readable", 64'(v[0]), 64'(1));
    reg_wr(7, 1);
    check(err_o == 1'b0, "R9 error cleared", 64'(err_o), 64'(0));
    reg_wr(3, 64);

    // disabled source ring
    reg_wr(1, 0);
    mem[28] = 32'h77770007;
    desc_wr(7, {16'h0, 16'd4, 32'h070});
    desc_wr(17, {16'h0, 16'd0, 32'h340});
    desc_raddr_i = IW'(17);
    reg_wr(6, 2);
    dc = done_cnt; rc = req_cnt;
    reg_wr(2, 0);
    repeat (30) @(negedge clk_i);
    reg_rd(2, v); check(v == 7, "R11 disabled index frozen", 64'(v), 64'(7));
    check(req_cnt == rc && done_cnt == dc, "R11 disabled ring idle", 64'(req_cnt - rc), 64'(0));
    expect_done({16'h0, 16'd4, 32'h340});
    reg_wr(1, 8);
    wait_done(6);
    check(mem[208] == 32'h77770007, "R11 runs after enable", 64'(mem[208]), 64'h77770007);
    reg_rd(2, v); check(v == 0, "R2 src index wraps", 64'(v), 64'(0));
    reg_rd(3, v); check(v == 7, "R3 src free after wrap", 64'(v), 64'(7));
    reg_rd(7, v); check(v[15:8] == 3, "R3 dst free after drain", 64'(v[15:8]), 64'(3));
    check(exp_q.size() == 0, "R7 all completions seen", 64'(exp_q.size()), 64'(0));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule